// File: doc/BRIEF.md
# Guest Preemption Countdown Timer

This block bounds how long a virtual-machine guest may run before control returns to the host. At guest entry it takes a 32-bit budget and a rate shift. It then measures elapsed time on a free-running time-stamp tick input after that input is shifted right by the rate. One unit of budget is used each time the shifted tick advances. When the budget runs out, the block raises a pending flag and a one-cycle asynchronous-event pulse, and it disarms itself. It then asks for a guest exit that carries a fixed reason code.

The block checks the control combination offered at entry. At any guest exit it can report the unused budget, clamped at zero. A local arbiter places the expiry among the other asynchronous events: debug traps are served first, then the timer, then non-maskable interrupts, then external interrupts. A pending expiry also wakes a halted core. A guest exit, an abort or a reset disarms the timer and drops any pending expiry.

Top module: `vm_preempt_timer`

## Requirements
- R1: After reset the block is out of guest mode, with no pending expiry, no exit request, no event pulse, no entry failure, no saved value and grant code 0.
- R2: The block latches the rate at entry. It expires at the first clock edge where (tick >> rate) − (entry_tick >> rate) ≥ loaded value, so expiry falls on a multiple of 2^rate ticks.
- R3: On expiry, pending_o rises together with a single-cycle async_evt_o pulse, and the timer disarms. Later tick growth gives no second pulse.
- R4: An entry with the exit control set and a value of 0 sets pending_o, with its async_evt_o pulse, at the entry edge, without arming.
- R5: When pending_o is set, the core is in guest mode and bit 6 of the pin-control word was set at entry, exit_req_o is high for exactly one cycle with exit_reason_o = 52. The pending flag clears at that edge.
- R6: The grant_o encoding is 0 none, 1 debug trap, 2 timer, 3 NMI, 4 external interrupt, in that order of priority. While dbg_trap_i is high the timer waits and exit_req_o stays low.
- R7: wake_o is high whenever halted_i and pending_o are both high.
- R8: An entry with store_ctl_i = 1 and pin-control bit 6 = 0 is refused. entry_fail_o pulses in the next cycle and guest mode is not entered.
- R9: exit_i disarms the timer and clears pending_o. If store_ctl_i was set at entry, save_valid_o and save_value_o = max(0, value − elapsed shifted ticks) appear in the same cycle as exit_i. The value is 0 once the timer has expired.
- R10: abort_i or reset leaves the block out of guest mode and disarmed, so no later expiry occurs.
- R11: With pin-control bit 6 clear at entry, the timer never arms and pending_o stays low however far the tick moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 64 | Free-running time-stamp tick |
| rate_i | input | 5 | Rate shift, latched at entry |
| entry_i | input | 1 | Guest entry strobe |
| entry_value_i | input | 32 | Timer budget loaded at entry |
| pin_ctl_i | input | 32 | Pin-based control word; bit 6 enables the timer exit |
| store_ctl_i | input | 1 | Save the remaining count at exit |
| exit_i | input | 1 | Guest exit acknowledge strobe |
| abort_i | input | 1 | Abort strobe |
| halted_i | input | 1 | Core is in a halted activity state |
| dbg_trap_i | input | 1 | Debug-trap event pending |
| nmi_i | input | 1 | NMI pending |
| ext_intr_i | input | 1 | External interrupt pending |
| in_guest_o | output | 1 | Guest mode active |
| pending_o | output | 1 | Expiry pending |
| async_evt_o | output | 1 | One-cycle asynchronous-event request on expiry |
| exit_req_o | output | 1 | Guest exit request pulse |
| exit_reason_o | output | 16 | Exit reason, 52 while exit_req_o is high |
| grant_o | output | 3 | Selected asynchronous event |
| wake_o | output | 1 | Leave the halted state |
| entry_fail_o | output | 1 | Entry refused for an invalid control combination |
| save_valid_o | output | 1 | Saved timer value valid |
| save_value_o | output | 32 | Remaining count to store |

## Verification
Expiry shows up on pending_o and async_evt_o one clock edge after the tick input first meets the threshold. exit_req_o, grant_o and wake_o then follow in the same cycle, with no further register. save_valid_o and save_value_o are combinational with exit_i, and entry_fail_o comes one edge after the entry strobe. The bench changes every input just after the falling edge and samples 4 ns later, just before the next rising edge. Its expected-event queue is therefore filled in the order the monitor pops same-cycle events: event pulse, exit request, saved value, entry failure.

// File: rtl/vm_preempt_pkg.sv
package vm_preempt_pkg;

    // Selected asynchronous event, ordered by service priority
    typedef enum logic [2:0] {
        GRANT_NONE   = 3'd0,
        GRANT_DEBUG  = 3'd1,
        GRANT_TIMER  = 3'd2,
        GRANT_NMI    = 3'd3,
        GRANT_EXTINT = 3'd4
    } grant_e;

endpackage

// File: rtl/vmpt_elapsed.sv
// Elapsed shifted-tick arithmetic: expiry compare and clamped remaining count.
module vmpt_elapsed #(
    parameter int TICK_W = 64,
    parameter int VAL_W  = 32,
    parameter int RATE_W = 5
) (
    input  logic [TICK_W-1:0] tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [TICK_W-1:0] load_shr_i,
    input  logic [VAL_W-1:0]  value_i,
    input  logic              armed_i,
    output logic              expired_o,
    output logic [VAL_W-1:0]  remaining_o
);
    localparam int HI_W = TICK_W - VAL_W;

    logic [TICK_W-1:0] now_shr;
    logic [TICK_W-1:0] elapsed;
    logic [VAL_W-1:0]  elapsed_lo;
    logic              high_nz;

    assign now_shr    = tick_i >> rate_i;
    assign elapsed    = now_shr - load_shr_i;
    assign elapsed_lo = elapsed[VAL_W-1:0];

    generate
        if (HI_W > 0) begin : g_hi
            assign high_nz = |elapsed[TICK_W-1:VAL_W];
        end else begin : g_nohi
            assign high_nz = 1'b0;
        end
    endgenerate

    assign expired_o   = armed_i && (high_nz || (elapsed_lo >= value_i));
    assign remaining_o = (!armed_i || expired_o) ? '0 : (value_i - elapsed_lo);
endmodule

// File: rtl/vmpt_entry_check.sv
// Control-combination check on a guest entry strobe.
module vmpt_entry_check #(
    parameter int CTL_W        = 32,
    parameter int EXIT_CTL_BIT = 6
) (
    input  logic             entry_i,
    input  logic             in_guest_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             store_i,
    output logic             accept_o,
    output logic             reject_o,
    output logic             exit_en_o
);
    logic entry_ok;
    logic unused_ctl;

    assign unused_ctl = ^ctl_i;
    assign exit_en_o  = ctl_i[EXIT_CTL_BIT];
    assign entry_ok   = entry_i && !in_guest_i;
    assign reject_o   = entry_ok && store_i && !exit_en_o;
    assign accept_o   = entry_ok && !reject_o;
endmodule

// File: rtl/vmpt_arbiter.sv
// Fixed-priority choice among asynchronous events.
module vmpt_arbiter
    import vm_preempt_pkg::*;
(
    input  logic   dbg_i,
    input  logic   tmr_i,
    input  logic   nmi_i,
    input  logic   ext_i,
    output grant_e grant_o
);
    always_comb begin
        if (dbg_i)      grant_o = GRANT_DEBUG;
        else if (tmr_i) grant_o = GRANT_TIMER;
        else if (nmi_i) grant_o = GRANT_NMI;
        else if (ext_i) grant_o = GRANT_EXTINT;
        else            grant_o = GRANT_NONE;
    end
endmodule

// File: rtl/vm_preempt_timer.sv
// Guest preemption countdown timer top level.
module vm_preempt_timer
    import vm_preempt_pkg::*;
#(
    parameter int TICK_W       = 64,
    parameter int VAL_W        = 32,
    parameter int RATE_W       = 5,
    parameter int CTL_W        = 32,
    parameter int EXIT_CTL_BIT = 6,
    parameter int REASON_W     = 16,
    parameter int EXIT_REASON  = 52
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TICK_W-1:0]   tick_i,
    input  logic [RATE_W-1:0]   rate_i,
    input  logic                entry_i,
    input  logic [VAL_W-1:0]    entry_value_i,
    input  logic [CTL_W-1:0]    pin_ctl_i,
    input  logic                store_ctl_i,
    input  logic                exit_i,
    input  logic                abort_i,
    input  logic                halted_i,
    input  logic                dbg_trap_i,
    input  logic                nmi_i,
    input  logic                ext_intr_i,
    output logic                in_guest_o,
    output logic                pending_o,
    output logic                async_evt_o,
    output logic                exit_req_o,
    output logic [REASON_W-1:0] exit_reason_o,
    output logic [2:0]          grant_o,
    output logic                wake_o,
    output logic                entry_fail_o,
    output logic                save_valid_o,
    output logic [VAL_W-1:0]    save_value_o
);
    localparam logic [REASON_W-1:0] REASON_CODE = REASON_W'(EXIT_REASON);

    typedef struct packed {
        logic              in_guest;
        logic              armed;
        logic              pending;
        logic              exit_en;
        logic              store;
        logic              async_evt;
        logic              fail;
        logic [RATE_W-1:0] rate;
        logic [TICK_W-1:0] load_shr;
        logic [VAL_W-1:0]  value;
    } state_t;

    state_t st_d, st_q;

    logic             expired;
    logic [VAL_W-1:0] remaining;
    logic             ent_accept, ent_reject, ent_exit_en;
    logic             tmr_ready;
    grant_e           grant;

    vmpt_elapsed #(
        .TICK_W (TICK_W),
        .VAL_W  (VAL_W),
        .RATE_W (RATE_W)
    ) u_elapsed (
        .tick_i      (tick_i),
        .rate_i      (st_q.rate),
        .load_shr_i  (st_q.load_shr),
        .value_i     (st_q.value),
        .armed_i     (st_q.armed),
        .expired_o   (expired),
        .remaining_o (remaining)
    );

    vmpt_entry_check #(
        .CTL_W        (CTL_W),
        .EXIT_CTL_BIT (EXIT_CTL_BIT)
    ) u_entry (
        .entry_i    (entry_i),
        .in_guest_i (st_q.in_guest),
        .ctl_i      (pin_ctl_i),
        .store_i    (store_ctl_i),
        .accept_o   (ent_accept),
        .reject_o   (ent_reject),
        .exit_en_o  (ent_exit_en)
    );

    assign tmr_ready = st_q.pending && st_q.in_guest && st_q.exit_en;

    vmpt_arbiter u_arb (
        .dbg_i   (dbg_trap_i),
        .tmr_i   (tmr_ready),
        .nmi_i   (nmi_i),
        .ext_i   (ext_intr_i),
        .grant_o (grant)
    );

    always_comb begin
        st_d           = st_q;
        st_d.async_evt = 1'b0;
        st_d.fail      = 1'b0;

        // Exit request consumes the pending expiry
        if (grant == GRANT_TIMER) begin
            st_d.pending = 1'b0;
        end

        // Count exhausted: flag, pulse, disarm
        if (expired) begin
            st_d.pending   = 1'b1;
            st_d.async_evt = 1'b1;
            st_d.armed     = 1'b0;
        end

        if (exit_i || abort_i) begin
            st_d.in_guest  = 1'b0;
            st_d.armed     = 1'b0;
            st_d.pending   = 1'b0;
            st_d.async_evt = 1'b0;
        end else if (ent_reject) begin
            st_d.fail = 1'b1;
        end else if (ent_accept) begin
            st_d.in_guest = 1'b1;
            st_d.exit_en  = ent_exit_en;
            st_d.store    = store_ctl_i;
            st_d.rate     = rate_i;
            st_d.load_shr = tick_i >> rate_i;
            st_d.value    = entry_value_i;
            st_d.armed    = 1'b0;
            st_d.pending  = 1'b0;
            if (ent_exit_en) begin
                if (entry_value_i == '0) begin
                    st_d.pending   = 1'b1;
                    st_d.async_evt = 1'b1;
                end else begin
                    st_d.armed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_guest_o    = st_q.in_guest;
    assign pending_o     = st_q.pending;
    assign async_evt_o   = st_q.async_evt;
    assign entry_fail_o  = st_q.fail;
    assign grant_o       = grant;
    assign exit_req_o    = (grant == GRANT_TIMER);
    assign exit_reason_o = exit_req_o ? REASON_CODE : '0;
    assign wake_o        = halted_i && st_q.pending;
    assign save_valid_o  = exit_i && st_q.in_guest && st_q.store;
    assign save_value_o  = save_valid_o ? remaining : '0;
endmodule

// File: rtl/vm_preempt_timer_chk.sv
// Temporal properties of the preemption timer, bound to the top module.
module vm_preempt_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic exit_i,
    input logic abort_i,
    input logic dbg_trap_i,
    input logic in_guest_o,
    input logic pending_o,
    input logic async_evt_o,
    input logic exit_req_o,
    input logic entry_fail_o,
    input logic save_valid_o
);
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) async_evt_o |=> !async_evt_o); // R3
    AST_EVT_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n) async_evt_o |-> pending_o); // R3
    AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) exit_req_o |=> !exit_req_o); // R5
    AST_EXIT_IN_GUEST: assert property (@(posedge clk) disable iff (!rst_n) exit_req_o |-> (in_guest_o && pending_o)); // R5
    AST_DEBUG_FIRST: assert property (@(posedge clk) disable iff (!rst_n) dbg_trap_i |-> !exit_req_o); // R6
    AST_FAIL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n) entry_fail_o |-> !in_guest_o); // R8
    AST_SAVE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n) save_valid_o |-> exit_i); // R9
    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) exit_i |=> (!pending_o && !in_guest_o)); // R9
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) abort_i |=> (!pending_o && !in_guest_o)); // R10
endmodule

bind vm_preempt_timer vm_preempt_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exit_i       (exit_i),
    .abort_i      (abort_i),
    .dbg_trap_i   (dbg_trap_i),
    .in_guest_o   (in_guest_o),
    .pending_o    (pending_o),
    .async_evt_o  (async_evt_o),
    .exit_req_o   (exit_req_o),
    .entry_fail_o (entry_fail_o),
    .save_valid_o (save_valid_o)
);

// File: tb/vm_preempt_timer_test.sv
module vm_preempt_timer_test;
    localparam int K_EVT  = 0;
    localparam int K_EXIT = 1;
    localparam int K_SAVE = 2;
    localparam int K_FAIL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tick_i = '0;
    logic [4:0]  rate_i = '0;
    logic        entry_i = 1'b0;
    logic [31:0] entry_value_i = '0;
    logic [31:0] pin_ctl_i = '0;
    logic        store_ctl_i = 1'b0;
    logic        exit_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        halted_i = 1'b0;
    logic        dbg_trap_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        ext_intr_i = 1'b0;
    logic        in_guest_o, pending_o, async_evt_o, exit_req_o, wake_o;
    logic        entry_fail_o, save_valid_o;
    logic [15:0] exit_reason_o;
    logic [2:0]  grant_o;
    logic [31:0] save_value_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;
        longint      val;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    vm_preempt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_i(rate_i),
        .entry_i(entry_i), .entry_value_i(entry_value_i), .pin_ctl_i(pin_ctl_i),
        .store_ctl_i(store_ctl_i), .exit_i(exit_i), .abort_i(abort_i),
        .halted_i(halted_i), .dbg_trap_i(dbg_trap_i), .nmi_i(nmi_i),
        .ext_intr_i(ext_intr_i), .in_guest_o(in_guest_o), .pending_o(pending_o),
        .async_evt_o(async_evt_o), .exit_req_o(exit_req_o),
        .exit_reason_o(exit_reason_o), .grant_o(grant_o), .wake_o(wake_o),
        .entry_fail_o(entry_fail_o), .save_valid_o(save_valid_o),
        .save_value_o(save_value_o)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(int kind, longint val, string req);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic pop_cmp(int kind, longint val);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected event kind actual=%0d expected=none", kind);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.val != val) begin
                fails++;
                $display("FAIL %s event actual=%0d/%0d expected=%0d/%0d",
                         e.req, kind, val, e.kind, e.val);
            end
        end
    endtask

    // Monitor: samples just before each rising edge
    always begin
        @(negedge clk);
        #4;
        if (async_evt_o)  pop_cmp(K_EVT, 0);
        if (exit_req_o)   pop_cmp(K_EXIT, longint'(exit_reason_o));
        if (save_valid_o) pop_cmp(K_SAVE, longint'(save_value_o));
        if (entry_fail_o) pop_cmp(K_FAIL, 0);
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #4;
    endtask

    task automatic enter(int unsigned v, bit ctl6, bit store, int rate, longint t);
        step();
        tick_i        = 64'(t);
        entry_value_i = v;
        pin_ctl_i     = ctl6 ? 32'h0000_0041 : 32'h0000_0001;
        store_ctl_i   = store;
        rate_i        = 5'(rate);
        entry_i       = 1'b1;
        step();
        entry_i       = 1'b0;
    endtask

    task automatic leave();
        step();
        exit_i = 1'b1;
        settle();
        step();
        exit_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 in_guest", in_guest_o, 0);
        chk("R1 pending", pending_o, 0);
        chk("R1 exit_req", exit_req_o, 0);
        chk("R1 async", async_evt_o, 0);
        chk("R1 grant", grant_o, 0);
        chk("R1 fail", entry_fail_o, 0);
        chk("R1 save_valid", save_valid_o, 0);

        // R2 rate 0, value 5 from tick 100
        enter(5, 1, 1, 0, 100);
        settle();
        chk("R2 entered", in_guest_o, 1);
        step(); tick_i = 104;
        step(); settle();
        chk("R2 no early expiry", pending_o, 0);
        push(K_EVT, 0, "R3");
        push(K_EXIT, 52, "R5");
        step(); tick_i = 105;
        step(); settle();
        chk("R3 pending on expiry", pending_o, 1);
        chk("R5 exit request", exit_req_o, 1);
        step(); settle();
        chk("R5 pending consumed", pending_o, 0);
        chk("R3 single pulse", async_evt_o, 0);
        step(); tick_i = 1000;
        step(); settle();
        chk("R3 disarmed", pending_o, 0);
        push(K_SAVE, 0, "R9 after expiry");
        leave();
        settle();
        chk("R9 left guest", in_guest_o, 0);

        // R2 rate 3 alignment: load 13 -> expiry at tick 24
        enter(2, 1, 0, 3, 13);
        step(); rate_i = 0; tick_i = 23;
        step(); settle();
        chk("R2 aligned not yet", pending_o, 0);
        push(K_EVT, 0, "R2");
        push(K_EXIT, 52, "R2");
        step(); tick_i = 24;
        step(); settle();
        chk("R2 aligned expiry", pending_o, 1);
        leave();

        // R9 readback: rate 2, value 10, load 8, exit at 21 -> 7
        enter(10, 1, 1, 2, 8);
        push(K_SAVE, 7, "R9 remaining");
        step(); tick_i = 21; exit_i = 1'b1;
        settle();
        step(); exit_i = 1'b0;
        settle();
        chk("R9 readback exit", in_guest_o, 0);

        // R9 clamp: elapsed beyond value in the exit cycle
        enter(3, 1, 1, 0, 50);
        push(K_SAVE, 0, "R9 clamp");
        step(); tick_i = 60; exit_i = 1'b1;
        settle();
        step(); exit_i = 1'b0;
        settle();
        chk("R9 exit wins over expiry", pending_o, 0);

        // R4 zero load
        push(K_EVT, 0, "R4");
        push(K_EXIT, 52, "R4");
        enter(0, 1, 0, 0, 200);
        settle();
        chk("R4 immediate pending", pending_o, 1);
        step(); settle();
        chk("R4 pending consumed", pending_o, 0);
        leave();

        // R8 invalid control combination
        push(K_FAIL, 0, "R8");
        enter(77, 0, 1, 0, 0);
        settle();
        chk("R8 not entered", in_guest_o, 0);
        step(); settle();
        chk("R8 pulse ends", entry_fail_o, 0);

        // R11 exit control clear
        enter(1, 0, 0, 0, 300);
        step(); tick_i = 5000;
        step(); settle();
        chk("R11 in guest", in_guest_o, 1);
        chk("R11 never pending", pending_o, 0);
        leave();

        // R6 and R7: priority and wake
        enter(2, 1, 0, 0, 400);
        push(K_EVT, 0, "R6");
        step(); tick_i = 402; dbg_trap_i = 1'b1; halted_i = 1'b1;
        step(); settle();
        chk("R6 debug granted", grant_o, 1);
        chk("R6 timer held", exit_req_o, 0);
        chk("R7 wake", wake_o, 1);
        step(); settle();
        chk("R6 still pending", pending_o, 1);
        push(K_EXIT, 52, "R6");
        step(); dbg_trap_i = 1'b0; nmi_i = 1'b1; ext_intr_i = 1'b1;
        settle();
        chk("R6 timer over nmi", grant_o, 2);
        step(); halted_i = 1'b0;
        settle();
        chk("R6 nmi next", grant_o, 3);
        chk("R7 no wake", wake_o, 0);
        step(); nmi_i = 1'b0;
        settle();
        chk("R6 ext last", grant_o, 4);
        step(); ext_intr_i = 1'b0;
        leave();

        // R9 exit clears a held pending expiry
        enter(1, 1, 1, 0, 500);
        push(K_EVT, 0, "R9");
        step(); dbg_trap_i = 1'b1; tick_i = 501;
        step(); settle();
        chk("R9 held pending", pending_o, 1);
        push(K_SAVE, 0, "R9 held");
        step(); exit_i = 1'b1;
        settle();
        step(); exit_i = 1'b0; dbg_trap_i = 1'b0;
        settle();
        chk("R9 pending cleared", pending_o, 0);
        chk("R9 out of guest", in_guest_o, 0);

        // R10 abort
        enter(4, 1, 0, 0, 600);
        step(); abort_i = 1'b1;
        step(); abort_i = 1'b0; tick_i = 700;
        step(); step(); settle();
        chk("R10 abort guest", in_guest_o, 0);
        chk("R10 abort pending", pending_o, 0);

        // R10 reset
        enter(4, 1, 0, 0, 800);
        step(); rst_n = 1'b0;
        step(); rst_n = 1'b1; tick_i = 900;
        step(); step(); settle();
        chk("R10 reset guest", in_guest_o, 0);
        chk("R10 reset pending", pending_o, 0);

        step();
        chk("scoreboard drained", longint'(sb.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule